// File: doc/BRIEF.md
# Trace Operand Data Serializer

This block watches the load and store operands of a processor and streams selected ones out on a 4-bit trace bus, one nibble per clock. A 2-bit capture mode decides whether reads, writes, both or neither are taken. Each taken operand goes out as a size marker nibble followed by its data nibbles. The data is sent least-significant nibble first.

The engine sends one operand at a time. A single holding register keeps one more operand that arrives during a transfer. That operand goes out directly behind the current one, with no idle cycle between them. If a further operand arrives while the holding register is full and the current transfer is not finishing, it is dropped and a sticky overflow flag is raised. A trace-off input clears the engine and holds every output at zero.

Top module: `trc_operand_serializer`

## Requirements
- R1: After reset, trcNibble is 0 and trcValid, busy and overflow are all low.
- R2: An operand is taken only when opValid is high, opSize is not 0 and the capture mode allows it. capMode 2'b00 takes none, 2'b01 takes writes only (opIsWrite=1), 2'b10 takes reads only (opIsWrite=0) and 2'b11 takes both. Any other operand is ignored.
- R3: An operand taken while the engine is idle and the holding register is empty is announced in the cycle after its sampling edge. In that cycle trcValid is 1 and trcNibble carries the marker: 1 for a byte (opSize 1), 2 for a word (opSize 2) and 3 for a long (opSize 3).
- R4: The data nibbles follow the marker, one per clock, least-significant first. A byte sends 2 nibbles, a word sends 4 and a long sends 8.
- R5: While no transfer is in progress, trcValid is low and trcNibble is 0.
- R6: An operand taken during a transfer waits in a one-entry holding register. Its marker follows the last data nibble of the current transfer with no idle cycle in between.
- R7: An operand taken while the holding register is full, in a cycle where the current transfer is not on its last nibble, is dropped. In that case overflow goes high and stays high until reset.
- R8: While traceOff is high, trcValid, trcNibble, busy and overflow are 0 in the same cycle and operands are ignored. Any transfer in progress and any held operand are discarded. The overflow flag is kept internally.
- R9: busy is high exactly while a transfer is in progress or the holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capMode | input | 2 | Capture mode: 00 none, 01 writes, 10 reads, 11 both |
| traceOff | input | 1 | Forces outputs quiescent and flushes the engine |
| opValid | input | 1 | Operand strobe |
| opIsWrite | input | 1 | 1 = store operand, 0 = load operand |
| opSize | input | 2 | 1 byte, 2 word, 3 long, 0 none |
| opData | input | 32 | Operand data, right-aligned |
| trcNibble | output | 4 | Trace nibble bus |
| trcValid | output | 1 | Nibble on the bus is valid |
| busy | output | 1 | Transfer in progress or operand held |
| overflow | output | 1 | Sticky operand-drop flag |

## Verification
When the engine is idle, a taken operand's marker appears one clock edge after the edge that samples the strobe. Each data nibble then follows one edge after the one before it. A held operand's marker follows one edge after its predecessor's last nibble. The trace-off masking is combinational, so it takes effect in the same cycle, and a drop raises overflow one edge after the sampling edge. The bench drives inputs just after a rising edge. It advances a behavioural queue model at each rising edge and compares all four outputs at the falling edge, which is where each of these delays has settled.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic flush;     // discard engine contents
    logic loadHold;  // start a transfer from the holding register
    logic loadIn;    // start a transfer straight from the inputs
    logic holdWr;    // capture the inputs into the holding register
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_READ  = 2'b10,
    MODE_BOTH  = 2'b11
  } capMode_e;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] capMode,
  input  logic       traceOff,
  input  logic       opValid,
  input  logic       opIsWrite,
  input  logic [1:0] opSize,
  input  logic       engActive,
  input  logic       engLast,
  output ctlStrobe_t strb,
  output logic       holdFull,
  output logic       ovfFlag
);
  logic modeOk;
  logic accept;
  logic engFree;
  logic dropNow;

  always_comb begin
    unique case (capMode_e'(capMode))
      MODE_NONE:  modeOk = 1'b0;
      MODE_WRITE: modeOk = opIsWrite;
      MODE_READ:  modeOk = !opIsWrite;
      MODE_BOTH:  modeOk = 1'b1;
      default:    modeOk = 1'b0;
    endcase
  end

  assign accept  = opValid && (opSize != 2'd0) && modeOk && !traceOff;
  assign engFree = !engActive || engLast;

  always_comb begin
    strb          = '0;
    strb.flush    = traceOff;
    strb.loadHold = !traceOff && engFree && holdFull;
    strb.loadIn   = engFree && !holdFull && accept;
    strb.holdWr   = accept && !strb.loadIn && (!holdFull || strb.loadHold);
  end

  assign dropNow = accept && holdFull && !strb.loadHold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (traceOff)           holdFull <= 1'b0;
      else if (strb.holdWr)   holdFull <= 1'b1;
      else if (strb.loadHold) holdFull <= 1'b0;
      if (dropNow) ovfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/trc_dpath.sv
module trc_dpath
  import trc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] opData,
  output logic              engActive,
  output logic              engLast,
  output logic [NIB_W-1:0]  curNib
);
  localparam int NIBS_MAX = DATA_W / NIB_W;
  localparam int CNT_W    = $clog2(NIBS_MAX + 1);

  logic [DATA_W-1:0] holdData;
  logic [1:0]        holdSize;
  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] selData;
  logic [1:0]        selSize;

  function automatic logic [CNT_W-1:0] nibsFor(input logic [1:0] sz);
    int bits;
    bits = (sz == 2'd0) ? 0 : (8 << (int'(sz) - 1));
    return CNT_W'(bits / NIB_W);
  endfunction

  assign selData = strb.loadHold ? holdData : opData;
  assign selSize = strb.loadHold ? holdSize : opSize;
  assign engLast = engActive && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdData  <= '0;
      holdSize  <= '0;
      shReg     <= '0;
      remain    <= '0;
      curNib    <= '0;
      engActive <= 1'b0;
    end else begin
      if (strb.holdWr) begin
        holdData <= opData;
        holdSize <= opSize;
      end
      if (strb.flush) begin
        engActive <= 1'b0;
        remain    <= '0;
      end else if (strb.loadHold || strb.loadIn) begin
        engActive <= 1'b1;
        curNib    <= NIB_W'(selSize);
        shReg     <= selData;
        remain    <= nibsFor(selSize);
      end else if (engActive) begin
        if (remain == '0) begin
          engActive <= 1'b0;
        end else begin
          curNib <= shReg[NIB_W-1:0];
          shReg  <= shReg >> NIB_W;
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trc_operand_serializer.sv
module trc_operand_serializer
  import trc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        capMode,
  input  logic              traceOff,
  input  logic              opValid,
  input  logic              opIsWrite,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] opData,
  output logic [NIB_W-1:0]  trcNibble,
  output logic              trcValid,
  output logic              busy,
  output logic              overflow
);
  ctlStrobe_t       strb;
  logic             engActive;
  logic             engLast;
  logic             holdFull;
  logic             ovfFlag;
  logic [NIB_W-1:0] curNib;

  trc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .capMode(capMode), .traceOff(traceOff),
    .opValid(opValid), .opIsWrite(opIsWrite), .opSize(opSize),
    .engActive(engActive), .engLast(engLast), .strb(strb),
    .holdFull(holdFull), .ovfFlag(ovfFlag)
  );

  trc_dpath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .opSize(opSize), .opData(opData),
    .engActive(engActive), .engLast(engLast), .curNib(curNib)
  );

  assign trcValid  = engActive && !traceOff;
  assign trcNibble = trcValid ? curNib : '0;
  assign busy      = (engActive || holdFull) && !traceOff;
  assign overflow  = ovfFlag && !traceOff;
endmodule

// File: rtl/trc_serializer_chk.sv
module trc_serializer_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       capMode,
  input logic             traceOff,
  input logic             opValid,
  input logic [NIB_W-1:0] trcNibble,
  input logic             trcValid,
  input logic             busy,
  input logic             overflow
);
  // R5: quiet bus when nothing is valid
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !trcValid |-> trcNibble == '0);

  // R8: trace-off masks every output
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    traceOff |-> (!trcValid && !busy && !overflow && trcNibble == '0));

  // R7: overflow never clears while tracing stays on
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !traceOff) |=> (traceOff || overflow));

  // R9: a valid nibble implies busy
  a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    trcValid |-> busy);

  // R2: mode 00 starts nothing from idle
  a_r2_mode_none: assert property (@(posedge clk) disable iff (!rst_n)
    (capMode == 2'b00 && opValid && !busy) |=> !trcValid);

  // R3: every transfer opens with a size marker
  a_r3_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trcValid) |-> (trcNibble inside {4'd1, 4'd2, 4'd3}));
endmodule

bind trc_operand_serializer trc_serializer_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .capMode(capMode), .traceOff(traceOff),
  .opValid(opValid), .trcNibble(trcNibble), .trcValid(trcValid),
  .busy(busy), .overflow(overflow)
);

// File: tb/sim_trc_operand_serializer.sv
`timescale 1ns/1ps
module sim_trc_operand_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  capMode = 2'b11;
  logic        traceOff = 1'b0;
  logic        opValid = 1'b0;
  logic        opIsWrite = 1'b0;
  logic [1:0]  opSize = 2'd0;
  logic [31:0] opData = '0;
  logic [3:0]  trcNibble;
  logic        trcValid, busy, overflow;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  trc_operand_serializer u0 (
    .clk(clk), .rst_n(rst_n), .capMode(capMode), .traceOff(traceOff),
    .opValid(opValid), .opIsWrite(opIsWrite), .opSize(opSize), .opData(opData),
    .trcNibble(trcNibble), .trcValid(trcValid), .busy(busy), .overflow(overflow)
  );

  // behavioural reference: queues of nibbles
  int curQ[$];
  int holdQ[$];
  bit holdValid = 0;
  bit ovfM = 0;

  function automatic void buildItem(input int sz, input logic [31:0] d, ref int q[$]);
    int n;
    q.delete();
    q.push_back(sz);
    n = (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
    for (int i = 0; i < n; i++) q.push_back(int'((d >> (4 * i)) & 32'hF));
  endfunction

  always @(posedge clk) begin
    bit acc, free, modeOk;
    int newQ[$];
    if (!rst_n) begin
      curQ.delete(); holdQ.delete(); holdValid = 0; ovfM = 0;
    end else if (traceOff) begin
      curQ.delete(); holdQ.delete(); holdValid = 0;
    end else begin
      modeOk = (capMode == 2'b11) || (capMode == 2'b01 && opIsWrite) ||
               (capMode == 2'b10 && !opIsWrite);
      acc  = opValid && opSize != 0 && modeOk;
      free = curQ.size() <= 1;
      if (acc) buildItem(int'(opSize), opData, newQ);
      if (curQ.size() > 0) void'(curQ.pop_front());
      if (free) begin
        if (holdValid) begin
          curQ = holdQ; holdValid = 0;
          if (acc) begin holdQ = newQ; holdValid = 1; end
        end else if (acc) curQ = newQ;
      end else if (acc) begin
        if (!holdValid) begin holdQ = newQ; holdValid = 1; end
        else ovfM = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int eV, eN, eB, eO;
      eV = (!traceOff && curQ.size() > 0) ? 1 : 0;
      eN = eV ? curQ[0] : 0;
      eB = (!traceOff && (curQ.size() > 0 || holdValid)) ? 1 : 0;
      eO = (!traceOff && ovfM) ? 1 : 0;
      chk(traceOff ? "R8 trcValid" : "R3 trcValid", int'(trcValid), eV);
      chk(traceOff ? "R8 trcNibble" : "R4 trcNibble", int'(trcNibble), eN);
      chk(traceOff ? "R8 busy" : "R9 busy", int'(busy), eB);
      chk(traceOff ? "R8 overflow" : "R7 overflow", int'(overflow), eO);
    end
  end

  task automatic drive(input bit v, input bit w, input int sz, input logic [31:0] d);
    @(posedge clk); #2;
    opValid = v; opIsWrite = w; opSize = 2'(sz); opData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 32'h0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(trcValid), 0); chk("R1 nibble", int'(trcNibble), 0);
    chk("R1 busy", int'(busy), 0);      chk("R1 overflow", int'(overflow), 0);

    phase = "R3/R4 sizes";
    capMode = 2'b11;
    drive(1, 1, 1, 32'h0000_00A5); idle(4);
    drive(1, 0, 2, 32'h0000_C3E1); idle(6);
    drive(1, 1, 3, 32'h8765_4321); idle(10);
    @(negedge clk);
    chk("R5 idle valid", int'(trcValid), 0); chk("R5 idle nibble", int'(trcNibble), 0);

    phase = "R2 filter";
    capMode = 2'b01; drive(1, 0, 3, 32'hFFFF_FFFF); drive(1, 1, 1, 32'h5A); idle(4);
    capMode = 2'b10; drive(1, 1, 2, 32'h1234); drive(1, 0, 1, 32'h9C); idle(4);
    capMode = 2'b00; drive(1, 1, 3, 32'hDEAD_BEEF); drive(1, 0, 3, 32'h1); idle(3);
    capMode = 2'b11; drive(1, 1, 0, 32'h77); idle(3);
    @(negedge clk); chk("R2 ignored busy", int'(busy), 0);

    phase = "R6 hold";
    drive(1, 1, 1, 32'h3C); drive(1, 0, 2, 32'hB7D2); idle(10);
    drive(1, 1, 1, 32'h11); drive(0, 0, 0, 0); drive(1, 1, 1, 32'h22); idle(8);

    phase = "R7 overflow";
    drive(1, 1, 3, 32'hCAFE_F00D); drive(1, 1, 1, 32'h44); drive(1, 0, 2, 32'h5555);
    idle(20);
    @(negedge clk); chk("R7 sticky", int'(overflow), 1);

    phase = "R8 off";
    drive(1, 1, 3, 32'h0BAD_0BAD); drive(1, 1, 1, 32'h66); idle(2);
    @(posedge clk); #2 traceOff = 1'b1;
    drive(1, 1, 2, 32'h7777); idle(2);
    @(posedge clk); #2 traceOff = 1'b0;
    idle(3);
    @(negedge clk); chk("R8 flushed busy", int'(busy), 0);

    phase = "R9 mixed";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    for (int k = 0; k < 2000; k++) begin
      capMode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) begin @(posedge clk); #2 traceOff = ~traceOff; end
      drive(bit'($urandom_range(0, 2) == 0), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 3)), $urandom());
    end
    traceOff = 1'b0; idle(12);
    finishRun();
  end
endmodule